// File: doc/BRIEF.md
# Supervisor Timer Compare Interrupt Unit

This unit keeps two compare registers, one for a supervisor timer channel and one for a virtual-supervisor timer channel. It raises a level-sensitive pending line for each channel. The supervisor channel compares its register against the platform time value. The virtual-supervisor channel compares its register against that time plus a guest offset, with the sum wrapping modulo 2^W. Each comparison is unsigned greater-or-equal. A pending line stays high until its compare value is moved above the compared time, which normally happens through a new write.

The time value comes from outside, together with a tick strobe that marks a cycle in which the time has advanced. Each pending line is re-evaluated on every tick. It is also re-evaluated at once when its own compare register is written, with the new data checked against the present time. Software writes go through a simple port with a channel select, a data word and a write strobe. Both registers can be read back at all times.

Top module: `sup_timer_cmp`

## Requirements
- R1: On a cycle with `tick_i` high and no write to channel 0, `spend_o` becomes (`time_i` >= `scmp_o`, unsigned) at the next clock edge. The comparison includes equality.
- R2: Channel 1 evaluates against (`time_i` + `voff_i`) mod 2^W. An offset that makes the sum wrap is compared on the wrapped value.
- R3: Writing a compare value at or below the channel's present compared time sets that channel's pending output at the same edge that loads the register, without waiting for a tick.
- R4: Writing a compare value above the channel's present compared time clears that channel's pending output at the same edge that loads the register.
- R5: With a compare value of all ones, pending is high only while the compared time is all ones. It drops on the first tick after the time wraps to zero.
- R6: A synchronous active-high `rst` clears both compare registers and both pending outputs.
- R7: `scmp_o` and `vscmp_o` return the last value written to their channel. A write to one channel leaves the other channel's register unchanged.
- R8: In a cycle with neither a tick nor a write, both pending outputs and both registers hold, whatever `time_i` and `voff_i` do.
- R9: When a tick and a write to a channel fall in the same cycle, that channel's pending output is computed from the newly written data. The other channel follows the tick.
- R10: The write select `wr_sel_i` encodes the target: 0 selects the supervisor channel, 1 selects the virtual-supervisor channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | W | Free-running platform time |
| tick_i | input | 1 | Time has advanced this cycle; re-evaluate both channels |
| voff_i | input | W | Guest offset added to time for channel 1 |
| wr_en_i | input | 1 | Compare register write strobe |
| wr_sel_i | input | 1 | Write target: 0 supervisor, 1 virtual-supervisor |
| wr_data_i | input | W | Compare value to write |
| scmp_o | output | W | Supervisor compare register read-back |
| vscmp_o | output | W | Virtual-supervisor compare register read-back |
| spend_o | output | 1 | Supervisor timer pending |
| vspend_o | output | 1 | Virtual-supervisor timer pending |

## Verification
A tick and a compare write can land on the same cycle. The bench provokes this by driving both in one cycle, with the old compare value chosen to assert pending and the new one chosen to clear it. It then checks that the written channel follows the new data while the untouched channel follows the tick. The bench also writes during quiet cycles that carry a time far from the last ticked one, to confirm that the write is judged against the present time.

// File: rtl/sup_timer_cmp_pkg.sv
package sup_timer_cmp_pkg;
    localparam int TIME_W = 64;
    localparam int NUM_CH = 2;

    typedef enum logic {
        CH_SUP = 1'b0,
        CH_VS  = 1'b1
    } chan_e;
endpackage

// File: rtl/stc_time_adj.sv
module stc_time_adj #(
    parameter int W = 64
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] off_i,
    output logic [W-1:0] adj_o
);
    // Modulo 2^W sum: the carry out is dropped on purpose.
    always_comb begin
        adj_o = base_i + off_i;
    end
endmodule

// File: rtl/stc_chan.sv
module stc_chan #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ctime_i,
    input  logic         tick_i,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cmp_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] cmp;
        logic         pend;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.cmp  = wdata_i;
            st_d.pend = (ctime_i >= wdata_i);
        end else if (tick_i) begin
            st_d.pend = (ctime_i >= st_q.cmp);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o  = st_q.cmp;
    assign pend_o = st_q.pend;
endmodule

// File: rtl/sup_timer_cmp.sv
module sup_timer_cmp
    import sup_timer_cmp_pkg::*;
#(
    parameter int W = TIME_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] time_i,
    input  logic         tick_i,
    input  logic [W-1:0] voff_i,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] scmp_o,
    output logic [W-1:0] vscmp_o,
    output logic         spend_o,
    output logic         vspend_o
);
    logic [W-1:0] ctime [NUM_CH];
    logic [W-1:0] cmp   [NUM_CH];
    logic         pend  [NUM_CH];
    logic [W-1:0] vtime;

    stc_time_adj #(.W(W)) u_adj (
        .base_i (time_i),
        .off_i  (voff_i),
        .adj_o  (vtime)
    );

    assign ctime[CH_SUP] = time_i;
    assign ctime[CH_VS]  = vtime;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic ch_we;
        assign ch_we = wr_en_i && (wr_sel_i == 1'(g));

        stc_chan #(.W(W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ctime_i (ctime[g]),
            .tick_i  (tick_i),
            .we_i    (ch_we),
            .wdata_i (wr_data_i),
            .cmp_o   (cmp[g]),
            .pend_o  (pend[g])
        );
    end

    assign scmp_o   = cmp[CH_SUP];
    assign vscmp_o  = cmp[CH_VS];
    assign spend_o  = pend[CH_SUP];
    assign vspend_o = pend[CH_VS];
endmodule

// File: rtl/sup_timer_cmp_chk.sv
module sup_timer_cmp_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] time_i,
    input logic         tick_i,
    input logic [W-1:0] voff_i,
    input logic         wr_en_i,
    input logic         wr_sel_i,
    input logic [W-1:0] wr_data_i,
    input logic [W-1:0] scmp_o,
    input logic [W-1:0] vscmp_o,
    input logic         spend_o,
    input logic         vspend_o
);
    logic [W-1:0] vt;
    logic         pv_q;

    assign vt = time_i + voff_i;

    always_ff @(posedge clk) begin
        pv_q <= 1'b1;
    end

    p_rst_clear_r6: assert property (@(posedge clk)
        (pv_q && $past(rst)) |-> (scmp_o == '0 && vscmp_o == '0 && !spend_o && !vspend_o));

    p_wr_sup_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wr_sel_i) |=>
            (scmp_o == $past(wr_data_i)) && (spend_o == ($past(time_i) >= $past(wr_data_i))));

    p_wr_vs_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i) |=>
            (vscmp_o == $past(wr_data_i)) && (vspend_o == ($past(vt) >= $past(wr_data_i))));

    p_tick_sup_r1: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !(wr_en_i && !wr_sel_i)) |=> (spend_o == ($past(time_i) >= $past(scmp_o))));

    p_tick_vs_r9: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !(wr_en_i && wr_sel_i)) |=> (vspend_o == ($past(vt) >= $past(vscmp_o))));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !wr_en_i) |=>
            ($stable(spend_o) && $stable(vspend_o) && $stable(scmp_o) && $stable(vscmp_o)));

    p_iso_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wr_sel_i) |=> $stable(vscmp_o));
endmodule

bind sup_timer_cmp sup_timer_cmp_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .time_i    (time_i),
    .tick_i    (tick_i),
    .voff_i    (voff_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .scmp_o    (scmp_o),
    .vscmp_o   (vscmp_o),
    .spend_o   (spend_o),
    .vspend_o  (vspend_o)
);

// File: tb/sup_timer_cmp_test.sv
`timescale 1ns/1ps
module sup_timer_cmp_test;
    localparam int W = 64;
    localparam logic [W-1:0] ONES = '1;

    typedef struct {
        logic [W-1:0] scmp;
        logic [W-1:0] vcmp;
        logic         sp;
        logic         vp;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] time_i = '0;
    logic         tick_i = 1'b0;
    logic [W-1:0] voff_i = '0;
    logic         wr_en_i = 1'b0;
    logic         wr_sel_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic [W-1:0] scmp_o, vscmp_o;
    logic         spend_o, vspend_o;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    logic [W-1:0] m_sc = '0, m_vc = '0;
    logic         m_sp = 1'b0, m_vp = 1'b0;

    always #2.5 clk = ~clk;

    sup_timer_cmp #(.W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .time_i    (time_i),
        .tick_i    (tick_i),
        .voff_i    (voff_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .scmp_o    (scmp_o),
        .vscmp_o   (vscmp_o),
        .spend_o   (spend_o),
        .vspend_o  (vspend_o)
    );

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic step(input bit r, input bit we, input bit sel, input logic [W-1:0] wd,
                        input bit tk, input logic [W-1:0] t, input logic [W-1:0] off,
                        input string tag);
        logic [W-1:0] tv;
        exp_t e;
        @(negedge clk);
        rst = r; wr_en_i = we; wr_sel_i = sel; wr_data_i = wd;
        tick_i = tk; time_i = t; voff_i = off;
        tv = t + off;
        if (r) begin
            m_sc = '0; m_vc = '0; m_sp = 1'b0; m_vp = 1'b0;
        end else begin
            if (we && !sel) begin m_sc = wd; m_sp = (t >= wd); end
            else if (tk) m_sp = (t >= m_sc);
            if (we && sel) begin m_vc = wd; m_vp = (tv >= wd); end
            else if (tk) m_vp = (tv >= m_vc);
        end
        e.scmp = m_sc; e.vcmp = m_vc; e.sp = m_sp; e.vp = m_vp; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: samples just after the edge that consumes the queued cycle.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (scmp_o !== e.scmp || vscmp_o !== e.vcmp || spend_o !== e.sp || vspend_o !== e.vp) begin
                n_bad++;
                $display("FAIL %s: got scmp=%h vcmp=%h sp=%b vp=%b, exp scmp=%h vcmp=%h sp=%b vp=%b",
                         e.tag, scmp_o, vscmp_o, spend_o, vspend_o, e.scmp, e.vcmp, e.sp, e.vp);
            end
        end
    end

    initial begin
        // R6 reset clears everything
        step(1, 1, 0, 64'h55, 1, 64'd9, 64'd0, "R6");
        step(1, 0, 0, 0, 0, 64'd9, 64'd0, "R6");
        // R8: time moves but no tick, pend stays low
        step(0, 0, 0, 0, 0, 64'd5, 64'd0, "R8");
        // R1: tick at time 5 vs cmp 0
        step(0, 0, 0, 0, 1, 64'd5, 64'd0, "R1");
        // R4/R10: future value on sel 0 clears supervisor
        step(0, 1, 0, 64'd100, 0, 64'd50, 64'd0, "R4");
        step(0, 0, 0, 0, 1, 64'd99, 64'd0, "R1");
        step(0, 0, 0, 0, 1, 64'd100, 64'd0, "R1");
        step(0, 0, 0, 0, 1, 64'd101, 64'd0, "R1");
        // R4: future write clears at once
        step(0, 1, 0, 64'd500, 0, 64'd101, 64'd0, "R4");
        // R3: past write asserts without tick
        step(0, 1, 0, 64'd80, 0, 64'd101, 64'd0, "R3");
        // R3: write judged against present time even if untricked
        step(0, 1, 0, 64'd300, 0, 64'd400, 64'd0, "R3");
        // R10/R7: sel 1 targets virtual channel only
        step(0, 1, 1, 64'd1050, 0, 64'd40, 64'd1000, "R10");
        step(0, 0, 0, 0, 1, 64'd50, 64'd1000, "R2");
        step(0, 1, 0, 64'd7, 0, 64'd50, 64'd1000, "R7");
        // R2: wrapping offset
        step(0, 1, 1, ONES - 64'd5, 0, 64'd5, ONES - 64'd9, "R2");
        step(0, 0, 0, 0, 1, 64'd10, ONES - 64'd9, "R2");
        // R8: offset and time jump without tick
        step(0, 0, 0, 0, 0, 64'd0, 64'd3, "R8");
        step(0, 0, 0, 0, 0, ONES, ONES, "R8");
        // R5: all-ones compare
        step(0, 1, 0, ONES, 0, ONES - 64'd1, 64'd0, "R5");
        step(0, 0, 0, 0, 1, ONES, 64'd0, "R5");
        step(0, 0, 0, 0, 1, 64'd0, 64'd0, "R5");
        step(0, 1, 1, ONES, 1, ONES, 64'd0, "R5");
        step(0, 0, 0, 0, 1, 64'd0, 64'd0, "R5");
        // R9: tick and write same cycle; old sup cmp would assert
        step(0, 1, 0, 64'd100, 0, 64'd10, 64'd0, "R9");
        step(0, 1, 1, 64'd150, 0, 64'd10, 64'd0, "R9");
        step(0, 1, 0, 64'd300, 1, 64'd200, 64'd0, "R9");
        step(0, 1, 1, 64'd900, 1, 64'd200, 64'd0, "R9");
        step(0, 1, 1, 64'd10, 1, 64'd200, 64'd0, "R9");
        // R6: reset again after activity
        step(1, 0, 0, 0, 0, 64'd200, 64'd0, "R6");
        step(0, 0, 0, 0, 0, 64'd200, 64'd0, "R6");
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule